// File: doc/BRIEF.md
# Indirect Oscillator Configuration Channel

This block gives software indirect access to a small bank of clock-setting words through four registers on a 32-bit register bus. Software places a value in the outgoing data register. It then writes one control word that holds a device index, a function code, a direction flag and a launch flag. If the launch flag is set, the block runs a single read or write on the selected oscillator word at that clock edge. It also records whether the access was accepted in a two-bit status register.

The status register is the state of a small three-state machine:

- `ST_IDLE` means status 0.
- `ST_OK` means done only.
- `ST_FAIL` means done and error.

The transitions are:

- Any control write without the launch flag moves the machine to `ST_IDLE`.
- A launched access with function code 1 and an in-range device index moves it to `ST_OK`.
- Any other launched access moves it to `ST_FAIL`.
- With no control write, the machine holds its state.

The number of oscillator words (up to 16) and their reset values are parameters.

Top module: `cfg_txn_ctrl`

## Requirements
- R1: After reset, control reads 0x00100000, status, outgoing data and return data read 0, and each oscillator word holds its parameter reset value.
- R2: Control (offset 0xA8) stores the written word with bits [19:12], [29:26] and the launch bit 31 forced to 0. The device index is bits [11:0], the function code is bits [25:20] and the write direction is bit 30 (1 = write).
- R3: A control write with bit 31 = 0 sets status (offset 0xAC) to 0 and leaves the return data and the oscillator words unchanged.
- R4: A launched read (bit 30 = 0) with function 1 and device index below the entry count loads that word into return data (offset 0xA0). Status reads 1 (bit 0 done) on the next cycle.
- R5: A launched write (bit 30 = 1) that passes the same check copies outgoing data into the selected word, and status reads 1.
- R6: A launched access with a function code other than 1 sets status to 3 (done plus bit 1 error). Return data and all oscillator words stay unchanged.
- R7: The device index equal to the entry count minus one is accepted. An index equal to or above the entry count fails with status 3.
- R8: Outgoing data (offset 0xA4) reads back the last value written to it.
- R9: Reads of unmapped offsets return 0. Writes to unmapped offsets, to the return data offset and to the status offset change nothing.
- R10: Setting reserved control bits does not affect the launched access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |

## Verification
The stimulus table covers the following access patterns:

- Reads of the first and last valid words.
- A write followed by a read back of the same word.
- Launched reads and writes with an index just past the end.
- A wrong function code in both directions.
- A control word with every reserved bit set.

Comparing return data after each failed access separates a failed read from one that leaked into the return register. The read of word 1 after two failed writes shows whether a rejected write reached the bank. Directed steps check the following:

- A plain control write clears a latched error.
- Writes to read-only and unmapped offsets leave every register untouched.

// File: rtl/cfg_txn_pkg.sv
package cfg_txn_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 12;
    localparam int OSC_MAX  = 16;
    localparam int IDX_W    = $clog2(OSC_MAX);

    localparam logic [ADDR_W-1:0] OFS_RTN  = 12'hA0;
    localparam logic [ADDR_W-1:0] OFS_OUT  = 12'hA4;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 12'hA8;
    localparam logic [ADDR_W-1:0] OFS_STAT = 12'hAC;

    localparam int DEV_LSB  = 0;
    localparam int DEV_W    = 12;
    localparam int FUNC_LSB = 20;
    localparam int FUNC_W   = 6;
    localparam int DIR_BIT  = 30;
    localparam int GO_BIT   = 31;

    localparam logic [DATA_W-1:0] CTRL_KEEP  = 32'h43F0_0FFF;
    localparam logic [DATA_W-1:0] CTRL_RESET = 32'h0010_0000;
    localparam logic [FUNC_W-1:0] FUNC_OSC   = 6'd1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_OK   = 2'b01,
        ST_FAIL = 2'b11
    } txn_state_e;

endpackage

// File: rtl/cfg_txn_regdec.sv
module cfg_txn_regdec
    import cfg_txn_pkg::*;
#(
    parameter int N_OSC = 3
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] ctrl_q,
    input  logic [DATA_W-1:0] out_q,
    input  logic [DATA_W-1:0] rtn_q,
    input  logic [1:0]        stat_bits,
    output logic              ctrl_wr,
    output logic              out_wr,
    output logic              launch,
    output logic              dir_wr,
    output logic              txn_ok,
    output logic [IDX_W-1:0]  dev_idx,
    output logic [DATA_W-1:0] ctrl_next,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam logic [DEV_W-1:0] DEV_LIMIT = DEV_W'(N_OSC);

    logic [DEV_W-1:0]  dev_full;
    logic [FUNC_W-1:0] func;

    always_comb begin
        ctrl_wr   = bus_wr && (bus_addr == OFS_CTRL);
        out_wr    = bus_wr && (bus_addr == OFS_OUT);
        launch    = ctrl_wr && bus_wdata[GO_BIT];
        dir_wr    = bus_wdata[DIR_BIT];
        dev_full  = bus_wdata[DEV_LSB +: DEV_W];
        func      = bus_wdata[FUNC_LSB +: FUNC_W];
        txn_ok    = (func == FUNC_OSC) && (dev_full < DEV_LIMIT);
        dev_idx   = dev_full[IDX_W-1:0];
        ctrl_next = bus_wdata & CTRL_KEEP;
    end

    always_comb begin
        unique case (bus_addr)
            OFS_RTN:  bus_rdata = rtn_q;
            OFS_OUT:  bus_rdata = out_q;
            OFS_CTRL: bus_rdata = ctrl_q;
            OFS_STAT: bus_rdata = {{(DATA_W-2){1'b0}}, stat_bits};
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cfg_txn_seq.sv
module cfg_txn_seq
    import cfg_txn_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic       launch,
    input  logic       dir_wr,
    input  logic       txn_ok,
    output logic       osc_we,
    output logic       rtn_le,
    output logic [1:0] stat_bits
);
    txn_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (ctrl_wr) begin
            if (!launch)     state_d = ST_IDLE;
            else if (txn_ok) state_d = ST_OK;
            else             state_d = ST_FAIL;
        end
    end

    always_comb begin
        osc_we = launch && txn_ok && dir_wr;
        rtn_le = launch && txn_ok && !dir_wr;
        unique case (state_q)
            ST_IDLE: stat_bits = 2'b00;
            ST_OK:   stat_bits = 2'b01;
            ST_FAIL: stat_bits = 2'b11;
            default: stat_bits = 2'b00;
        endcase
    end
endmodule

// File: rtl/cfg_txn_osc_bank.sv
module cfg_txn_osc_bank
    import cfg_txn_pkg::*;
#(
    parameter int                        N_OSC    = 3,
    parameter logic [OSC_MAX*DATA_W-1:0] OSC_INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] word_q [N_OSC];

    for (genvar g = 0; g < N_OSC; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q[g] <= OSC_INIT[g*DATA_W +: DATA_W];
            else if (we && (idx == IDX_W'(g)))
                word_q[g] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < N_OSC; k++)
            if (idx == IDX_W'(k)) rdata = word_q[k];
    end
endmodule

// File: rtl/cfg_txn_ctrl.sv
module cfg_txn_ctrl
    import cfg_txn_pkg::*;
#(
    parameter int                        N_OSC    = 3,
    parameter logic [OSC_MAX*DATA_W-1:0] OSC_INIT =
        {{(OSC_MAX-3){32'h0}}, 32'd25_000_000, 32'd24_000_000, 32'd50_000_000}
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [11:0] bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata
);
    logic [DATA_W-1:0] ctrl_q, out_q, rtn_q, ctrl_next, osc_rd;
    logic              ctrl_wr, out_wr, launch, dir_wr, txn_ok, osc_we, rtn_le;
    logic [IDX_W-1:0]  dev_idx;
    logic [1:0]        stat_bits;

    cfg_txn_regdec #(.N_OSC(N_OSC)) u_dec (
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .ctrl_q(ctrl_q), .out_q(out_q), .rtn_q(rtn_q), .stat_bits(stat_bits),
        .ctrl_wr(ctrl_wr), .out_wr(out_wr), .launch(launch), .dir_wr(dir_wr),
        .txn_ok(txn_ok), .dev_idx(dev_idx), .ctrl_next(ctrl_next),
        .bus_rdata(bus_rdata)
    );

    cfg_txn_seq u_seq (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .launch(launch),
        .dir_wr(dir_wr), .txn_ok(txn_ok), .osc_we(osc_we), .rtn_le(rtn_le),
        .stat_bits(stat_bits)
    );

    cfg_txn_osc_bank #(.N_OSC(N_OSC), .OSC_INIT(OSC_INIT)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(osc_we), .idx(dev_idx),
        .wdata(out_q), .rdata(osc_rd)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
            out_q  <= '0;
            rtn_q  <= '0;
        end else begin
            if (ctrl_wr) ctrl_q <= ctrl_next;
            if (out_wr)  out_q  <= bus_wdata;
            if (rtn_le)  rtn_q  <= osc_rd;
        end
    end
endmodule

// File: rtl/cfg_txn_ctrl_chk.sv
module cfg_txn_ctrl_chk
    import cfg_txn_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [11:0] bus_addr,
    input logic        bus_wr,
    input logic [31:0] bus_wdata,
    input logic [31:0] ctrl_q,
    input logic [31:0] rtn_q,
    input logic [1:0]  stat_bits
);
    logic is_ctrl_wr;
    logic other_wr;
    assign is_ctrl_wr = bus_wr && (bus_addr == OFS_CTRL);
    assign other_wr   = bus_wr && (bus_addr != OFS_CTRL) && (bus_addr != OFS_OUT);

    // R2
    ctrl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_ctrl_wr |=> ctrl_q == ($past(bus_wdata) & CTRL_KEEP));

    // R3
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ctrl_wr && !bus_wdata[GO_BIT]) |=> stat_bits == 2'b00);

    // R3
    plain_rtn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ctrl_wr && !bus_wdata[GO_BIT]) |=> $stable(rtn_q));

    // R4
    launch_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ctrl_wr && bus_wdata[GO_BIT]) |=> stat_bits[0]);

    // R6
    bad_func_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ctrl_wr && bus_wdata[GO_BIT] && bus_wdata[FUNC_LSB +: FUNC_W] != FUNC_OSC)
        |=> (stat_bits == 2'b11) && $stable(rtn_q));

    // R6
    err_implies_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_bits[1] |-> stat_bits[0]);

    // R9
    other_wr_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        other_wr |=> $stable(ctrl_q) && $stable(stat_bits) && $stable(rtn_q));
endmodule

bind cfg_txn_ctrl cfg_txn_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .ctrl_q(ctrl_q), .rtn_q(rtn_q), .stat_bits(stat_bits)
);

// File: tb/sim_cfg_txn_ctrl.sv
module sim_cfg_txn_ctrl;
    localparam int NOSC = 4;
    localparam logic [31:0] I0 = 32'h1111_0000, I1 = 32'h2222_0001,
                            I2 = 32'h3333_0002, I3 = 32'h4444_0003;
    localparam logic [16*32-1:0] INIT = {{12{32'h0}}, I3, I2, I1, I0};
    localparam logic [31:0] KEEP = 32'h43F0_0FFF;

    // {outgoing data, control word, expected status, expected return data}
    localparam int NV = 10;
    localparam logic [97:0] VEC [NV] = '{
        {32'h0,         32'h8010_0000, 2'd1, I0},            // R4 first word
        {32'h0,         32'h8010_0003, 2'd1, I3},            // R7 last index valid
        {32'hCAFE_0002, 32'hC010_0002, 2'd1, I3},            // R5 write word 2
        {32'hCAFE_0002, 32'h8010_0002, 2'd1, 32'hCAFE_0002}, // R5 read back
        {32'hCAFE_0002, 32'h8010_0004, 2'd3, 32'hCAFE_0002}, // R7 index = count
        {32'hCAFE_0002, 32'h8020_0001, 2'd3, 32'hCAFE_0002}, // R6 bad function read
        {32'hDEAD_0000, 32'hC010_0004, 2'd3, 32'hCAFE_0002}, // R7 bad index write
        {32'hDEAD_0000, 32'hC000_0001, 2'd3, 32'hCAFE_0002}, // R6 bad function write
        {32'hDEAD_0000, 32'h8010_0001, 2'd1, I1},            // R6 word 1 untouched
        {32'hDEAD_0000, 32'hBC1F_F003, 2'd1, I3}             // R10 reserved bits set
    };

    logic        clk = 0, rst_n = 0, bus_wr = 0;
    logic [11:0] bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    cfg_txn_ctrl #(.N_OSC(NOSC), .OSC_INIT(INIT)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic chk(input logic [11:0] a, input logic [31:0] exp, input string req);
        bus_addr = a;
        #1;
        n_chk++;
        if (bus_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s offset %h: actual %h expected %h", req, a, bus_rdata, exp);
        end
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk(12'hA8, 32'h0010_0000, "R1");
        chk(12'hAC, 32'h0, "R1");
        chk(12'hA4, 32'h0, "R1");
        chk(12'hA0, 32'h0, "R1");
        wr(12'hA8, 32'h8010_0002);
        chk(12'hA0, I2, "R1");

        for (int i = 0; i < NV; i++) begin
            logic [31:0] o, c, r;
            logic [1:0]  s;
            {o, c, s, r} = VEC[i];
            wr(12'hA4, o);
            chk(12'hA4, o, "R8");
            wr(12'hA8, c);
            chk(12'hAC, {30'h0, s}, "R4/R5/R6/R7 status");
            chk(12'hA0, r, "R4/R5/R6/R7 return");
            chk(12'hA8, c & KEEP, "R2");
        end

        // R3 plain control write clears a latched error
        wr(12'hA8, 32'h8030_0000);
        chk(12'hAC, 32'h3, "R6");
        wr(12'hA8, 32'h7FFF_FFFF);
        chk(12'hAC, 32'h0, "R3");
        chk(12'hA8, 32'h43F0_0FFF, "R2");
        chk(12'hA0, I3, "R3");

        // R9 unmapped and read-only offsets
        chk(12'h000, 32'h0, "R9");
        chk(12'h0B0, 32'h0, "R9");
        wr(12'h0A0, 32'h5555_5555);
        wr(12'h0AC, 32'h3);
        wr(12'h010, 32'hFFFF_FFFF);
        chk(12'hA0, I3, "R9");
        chk(12'hAC, 32'h0, "R9");
        chk(12'hA8, 32'h43F0_0FFF, "R9");
        chk(12'h010, 32'h0, "R9");
        // R9 words unchanged, R8 outgoing data held
        chk(12'hA4, 32'hDEAD_0000, "R8");
        wr(12'hA8, 32'h8010_0000);
        chk(12'hA0, I0, "R9");
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule